// File: doc/BRIEF.md
# Serial Command Error Classifier

This block sits behind the command decoder of an agent on a serial host-to-agent transaction bus. When the command phase ends, it looks at the decoded command and sorts it into one of four response classes: normal, no-response, fatal error or non-fatal error. The inputs it judges are opcode and cycle-type validity, the command CRC check result, the flow-control state of the target channel, the packet sizes against the configured limits, the 4 KB page crossing and the short I/O port range. Any class other than normal also raises a discard flag, so the payload path drops the command.

The result is registered and held until the response generator acknowledges it. The block also follows chip select. It enables the response driver only while a response that drives the bus is pending and chip select is low. When chip select is removed before the response has been acknowledged, the block releases the bus, drops the pending result and raises a response-phase CRC error flag. That flag is raised only if CRC checking is enabled.

Top module: `cmd_err_classifier`

## Requirements
- R1: After reset, rsp_valid, data_oe and crc_rsp_err are 0 and discard is 0.
- R2: The class is no-response (rsp_class=2'b01) with discard=1 when opcode_ok=0, or cycle_ok=0, or crc_check_en=1 and crc_ok=0.
- R3: When crc_check_en=0, crc_ok has no effect on the class.
- R4: The class is fatal (2'b10) when is_put=1 and chan_free=0, or is_get=1 and chan_avail=0.
- R5: On the peripheral channel (channel=2'b00), the class is fatal when rd_req=0 and pay_len>max_payload, or rd_req=1 and rd_size>max_rd_size. On other channels these sizes are ignored.
- R6: On the peripheral channel, the class is fatal when addr[11:0] plus the length is above 4096. The length is rd_size if rd_req=1, otherwise pay_len.
- R7: On the virtual-wire channel (channel=2'b01), the class is fatal when vw_count>max_vw_count.
- R8: The class is non-fatal (2'b11) when io_short_only=1, is_io_short=1 and addr>0x100.
- R9: When several conditions apply, no-response outranks fatal and fatal outranks non-fatal. With no condition the class is normal (2'b00) and discard=0.
- R10: The result appears on rsp_valid/rsp_class one clock after cmd_valid. It is held unchanged until rsp_ack, which clears rsp_valid on the next clock. A cmd_valid while a result is pending is ignored.
- R11: data_oe is 1 only while a result is pending, cs_n is 0 and the class is not no-response. It falls in the same cycle that cs_n rises.
- R12: A transaction is open from a cs_n falling edge until rsp_ack. A cs_n rise while it is open clears rsp_valid and sets crc_rsp_err to crc_check_en. crc_rsp_err then holds until the next cs_n fall, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| cmd_valid | input | 1 | Command phase complete; inputs below are valid |
| opcode_ok | input | 1 | Decoder recognised the opcode |
| cycle_ok | input | 1 | Cycle type is supported |
| crc_ok | input | 1 | Command CRC matched |
| crc_check_en | input | 1 | CRC checking enabled |
| channel | input | 2 | 00 peripheral, 01 virtual wire, 10/11 other |
| is_put | input | 1 | Command is a PUT |
| is_get | input | 1 | Command is a GET |
| chan_free | input | 1 | Channel has signalled free |
| chan_avail | input | 1 | Channel has signalled available |
| rd_req | input | 1 | Peripheral command is a read request |
| pay_len | input | LEN_W | Payload length in bytes |
| rd_size | input | LEN_W | Read request size in bytes |
| max_payload | input | LEN_W | Configured payload limit |
| max_rd_size | input | LEN_W | Configured read request limit |
| addr | input | ADDR_W | Request address |
| vw_count | input | VW_W | Virtual-wire count |
| max_vw_count | input | VW_W | Configured virtual-wire limit |
| is_io_short | input | 1 | Command is a short I/O read or write |
| io_short_only | input | 1 | Only short I/O to ports 0x000..0x100 supported |
| rsp_ack | input | 1 | Response generator consumed the result |
| rsp_valid | output | 1 | Result pending |
| rsp_class | output | 2 | 00 normal, 01 no-response, 10 fatal, 11 non-fatal |
| discard | output | 1 | Pending command is to be dropped |
| data_oe | output | 1 | Response data bus drive enable |
| crc_rsp_err | output | 1 | Response-phase CRC error after an aborted transaction |

## Verification
The assertions assume that cs_n is already synchronous to clk. They also assume that rsp_ack arrives only while a result is pending and never in the same cycle as a cs_n rise, and that is_put and is_get are never both set. The stimulus takes its random values from $urandom with a fixed seed. It picks exactly one of PUT, GET or neither, and it sequences cs_n, cmd_valid and rsp_ack in a fixed order. Separate directed sequences cover a cs_n rise before the acknowledge and a cmd_valid while a result is pending.

// File: rtl/cec_pkg.sv
package cec_pkg;
  typedef enum logic [1:0] {
    CLS_NORMAL   = 2'b00,
    CLS_NO_RSP   = 2'b01,
    CLS_FATAL    = 2'b10,
    CLS_NONFATAL = 2'b11
  } rsp_class_e;

  localparam logic [1:0] CH_PERIPH = 2'b00;
  localparam logic [1:0] CH_VWIRE  = 2'b01;
endpackage

// File: rtl/cec_rank.sv
module cec_rank
  import cec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 13,
  parameter int VW_W   = 8,
  parameter int IO_TOP = 256,
  parameter int PAGE   = 4096
) (
  input  logic              opcode_ok,
  input  logic              cycle_ok,
  input  logic              crc_ok,
  input  logic              crc_check_en,
  input  logic [1:0]        channel,
  input  logic              is_put,
  input  logic              is_get,
  input  logic              chan_free,
  input  logic              chan_avail,
  input  logic              rd_req,
  input  logic [LEN_W-1:0]  pay_len,
  input  logic [LEN_W-1:0]  rd_size,
  input  logic [LEN_W-1:0]  max_payload,
  input  logic [LEN_W-1:0]  max_rd_size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [VW_W-1:0]   vw_count,
  input  logic [VW_W-1:0]   max_vw_count,
  input  logic              is_io_short,
  input  logic              io_short_only,
  output logic              nr_hit,
  output logic              fatal_hit,
  output logic              nf_hit,
  output rsp_class_e        cls
);
  localparam int OFF_W = $clog2(PAGE);
  localparam int SUM_W = (OFF_W > LEN_W ? OFF_W : LEN_W) + 2;

  function automatic logic crosses_page(input logic [OFF_W-1:0] off,
                                        input logic [LEN_W-1:0] len);
    logic [SUM_W-1:0] sum;
    sum = SUM_W'(off) + SUM_W'(len);
    return sum > SUM_W'(PAGE);
  endfunction

  logic periph, size_bad, page_bad, flow_bad, vw_bad;
  logic [LEN_W-1:0] req_len;

  always_comb begin
    periph    = (channel == CH_PERIPH);
    req_len   = rd_req ? rd_size : pay_len;
    size_bad  = periph && (rd_req ? (rd_size > max_rd_size) : (pay_len > max_payload));
    page_bad  = periph && crosses_page(addr[OFF_W-1:0], req_len);
    flow_bad  = (is_put && !chan_free) || (is_get && !chan_avail);
    vw_bad    = (channel == CH_VWIRE) && (vw_count > max_vw_count);
    nr_hit    = !opcode_ok || !cycle_ok || (crc_check_en && !crc_ok);
    fatal_hit = flow_bad || size_bad || page_bad || vw_bad;
    nf_hit    = io_short_only && is_io_short && (addr > ADDR_W'(IO_TOP));
    if (nr_hit)         cls = CLS_NO_RSP;
    else if (fatal_hit) cls = CLS_FATAL;
    else if (nf_hit)    cls = CLS_NONFATAL;
    else                cls = CLS_NORMAL;
  end
endmodule

// File: rtl/cec_hold.sv
module cec_hold
  import cec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  rsp_class_e cls_in,
  input  logic       clear,
  output logic       pending,
  output rsp_class_e cls_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      cls_q   <= CLS_NORMAL;
    end else if (clear) begin
      pending <= 1'b0;
    end else if (load && !pending) begin
      pending <= 1'b1;
      cls_q   <= cls_in;
    end
  end

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clear) |=> (pending && $stable(cls_q)));
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !pending);
endmodule

// File: rtl/cec_bus.sv
module cec_bus (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rsp_ack,
  input  logic crc_check_en,
  output logic abort,
  output logic crc_rsp_err
);
  logic cs_q, open_q, cs_fall;

  always_comb begin
    cs_fall = !cs_n && cs_q;
    abort   = cs_n && !cs_q && open_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q        <= 1'b1;
      open_q      <= 1'b0;
      crc_rsp_err <= 1'b0;
    end else begin
      cs_q <= cs_n;
      if (abort || rsp_ack) open_q <= 1'b0;
      else if (cs_fall)     open_q <= 1'b1;
      if (cs_fall)          crc_rsp_err <= 1'b0;
      else if (abort)       crc_rsp_err <= crc_check_en;
    end
  end

  assert_crc_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !crc_check_en) |=> !crc_rsp_err);
  assert_crc_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && crc_check_en) |=> crc_rsp_err);
endmodule

// File: rtl/cmd_err_classifier.sv
module cmd_err_classifier
  import cec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 13,
  parameter int VW_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cmd_valid,
  input  logic              opcode_ok,
  input  logic              cycle_ok,
  input  logic              crc_ok,
  input  logic              crc_check_en,
  input  logic [1:0]        channel,
  input  logic              is_put,
  input  logic              is_get,
  input  logic              chan_free,
  input  logic              chan_avail,
  input  logic              rd_req,
  input  logic [LEN_W-1:0]  pay_len,
  input  logic [LEN_W-1:0]  rd_size,
  input  logic [LEN_W-1:0]  max_payload,
  input  logic [LEN_W-1:0]  max_rd_size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [VW_W-1:0]   vw_count,
  input  logic [VW_W-1:0]   max_vw_count,
  input  logic              is_io_short,
  input  logic              io_short_only,
  input  logic              rsp_ack,
  output logic              rsp_valid,
  output logic [1:0]        rsp_class,
  output logic              discard,
  output logic              data_oe,
  output logic              crc_rsp_err
);
  logic       nr_hit, fatal_hit, nf_hit, abort;
  rsp_class_e cls_new, cls_held;

  cec_rank #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .VW_W(VW_W)) u_rank (
    .opcode_ok(opcode_ok), .cycle_ok(cycle_ok), .crc_ok(crc_ok),
    .crc_check_en(crc_check_en), .channel(channel), .is_put(is_put),
    .is_get(is_get), .chan_free(chan_free), .chan_avail(chan_avail),
    .rd_req(rd_req), .pay_len(pay_len), .rd_size(rd_size),
    .max_payload(max_payload), .max_rd_size(max_rd_size), .addr(addr),
    .vw_count(vw_count), .max_vw_count(max_vw_count),
    .is_io_short(is_io_short), .io_short_only(io_short_only),
    .nr_hit(nr_hit), .fatal_hit(fatal_hit), .nf_hit(nf_hit), .cls(cls_new)
  );

  cec_hold u_hold (
    .clk(clk), .rst_n(rst_n), .load(cmd_valid), .cls_in(cls_new),
    .clear(rsp_ack || abort), .pending(rsp_valid), .cls_q(cls_held)
  );

  cec_bus u_bus (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rsp_ack(rsp_ack),
    .crc_check_en(crc_check_en), .abort(abort), .crc_rsp_err(crc_rsp_err)
  );

  always_comb begin
    rsp_class = cls_held;
    discard   = rsp_valid && (cls_held != CLS_NORMAL);
    data_oe   = rsp_valid && !cs_n && (cls_held != CLS_NO_RSP);
  end

  assert_noresp_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !rsp_valid && !abort && !rsp_ack && nr_hit) |=> (rsp_valid && rsp_class == CLS_NO_RSP));
  assert_fatal_over_nf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !rsp_valid && !abort && !rsp_ack && !nr_hit && fatal_hit) |=> (rsp_class == CLS_FATAL));
  assert_nonfatal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !rsp_valid && !abort && !rsp_ack && !nr_hit && !fatal_hit && nf_hit) |=> (rsp_class == CLS_NONFATAL));
  assert_abort_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !rsp_valid);
endmodule

// File: tb/sim_cmd_err_classifier.sv
`timescale 1ns/1ps
module sim_cmd_err_classifier;
  localparam int AW = 32, LW = 13, VW = 8;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, cmd_valid = 0, opcode_ok = 1, cycle_ok = 1, crc_ok = 1, crc_check_en = 0;
  logic [1:0] channel = 0;
  logic is_put = 0, is_get = 0, chan_free = 1, chan_avail = 1, rd_req = 0;
  logic [LW-1:0] pay_len = 0, rd_size = 0, max_payload = 64, max_rd_size = 64;
  logic [AW-1:0] addr = 0;
  logic [VW-1:0] vw_count = 0, max_vw_count = 8;
  logic is_io_short = 0, io_short_only = 0, rsp_ack = 0;
  logic rsp_valid, discard, data_oe, crc_rsp_err;
  logic [1:0] rsp_class;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  cmd_err_classifier u0 (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_class();
    logic nr, ft, nf, per;
    int unsigned ln;
    per = (channel == 2'b00);
    ln  = rd_req ? int'(rd_size) : int'(pay_len);
    nr  = !opcode_ok || !cycle_ok || (crc_check_en && !crc_ok);
    ft  = (is_put && !chan_free) || (is_get && !chan_avail)
       || (per && !rd_req && pay_len > max_payload)
       || (per && rd_req && rd_size > max_rd_size)
       || (per && (int'(addr % 4096) + ln > 4096))
       || (channel == 2'b01 && vw_count > max_vw_count);
    nf  = io_short_only && is_io_short && addr > 32'h100;
    if (nr) return 2'b01;
    if (ft) return 2'b10;
    if (nf) return 2'b11;
    return 2'b00;
  endfunction

  task automatic run_cmd(input string tag);
    logic [1:0] e;
    @(negedge clk) cs_n = 0;
    @(negedge clk) cmd_valid = 1; e = ref_class();
    @(negedge clk) cmd_valid = 0;
    chk(rsp_valid, 1, {tag, " R10 valid"});
    chk(rsp_class, e, tag);
    chk(discard, e != 2'b00, {tag, " R9 discard"});
    chk(data_oe, e != 2'b01, {tag, " R11 oe"});
    rsp_ack = 1;
    @(negedge clk) rsp_ack = 0;
    chk(rsp_valid, 0, {tag, " R10 ack"});
    cs_n = 1;
    @(negedge clk) chk(crc_rsp_err, 0, {tag, " R12 no abort"});
  endtask

  task automatic clean();
    opcode_ok = 1; cycle_ok = 1; crc_ok = 1; crc_check_en = 0; channel = 2'b10;
    is_put = 0; is_get = 0; chan_free = 1; chan_avail = 1; rd_req = 0;
    pay_len = 0; rd_size = 0; addr = 0; vw_count = 0; is_io_short = 0; io_short_only = 0;
  endtask

  task automatic finish_up();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk(rsp_valid, 0, "R1 valid"); chk(data_oe, 0, "R1 oe");
    chk(crc_rsp_err, 0, "R1 crc"); chk(discard, 0, "R1 discard");
    rst_n = 1;
    // directed corners
    clean(); run_cmd("R9 normal");
    clean(); opcode_ok = 0; run_cmd("R2 opcode");
    clean(); cycle_ok = 0; run_cmd("R2 cycle");
    clean(); crc_check_en = 1; crc_ok = 0; run_cmd("R2 crc");
    clean(); crc_ok = 0; run_cmd("R3 crc off");
    clean(); is_put = 1; chan_free = 0; run_cmd("R4 put");
    clean(); is_get = 1; chan_avail = 0; run_cmd("R4 get");
    clean(); channel = 0; pay_len = 65; run_cmd("R5 payload");
    clean(); channel = 2'b11; pay_len = 65; run_cmd("R5 other chan");
    clean(); channel = 0; rd_req = 1; rd_size = 65; run_cmd("R5 rdsize");
    clean(); channel = 0; addr = 32'hFC0; pay_len = 64; run_cmd("R6 exact page");
    clean(); channel = 0; addr = 32'hFC1; pay_len = 64; run_cmd("R6 cross");
    clean(); channel = 1; vw_count = 9; run_cmd("R7 vw");
    clean(); io_short_only = 1; is_io_short = 1; addr = 32'h100; run_cmd("R8 edge");
    clean(); io_short_only = 1; is_io_short = 1; addr = 32'h101; run_cmd("R8 out");
    clean(); io_short_only = 1; is_io_short = 1; addr = 32'h101; is_put = 1; chan_free = 0;
    run_cmd("R9 fatal>nf");
    clean(); cycle_ok = 0; is_get = 1; chan_avail = 0; run_cmd("R9 nr>fatal");
    // R10: second cmd_valid while pending is ignored
    clean();
    @(negedge clk) cs_n = 0;
    @(negedge clk) cmd_valid = 1;
    @(negedge clk) opcode_ok = 0;
    @(negedge clk) cmd_valid = 0;
    chk(rsp_class, 2'b00, "R10 ignored reload");
    chk(rsp_valid, 1, "R10 held");
    rsp_ack = 1; @(negedge clk) rsp_ack = 0; cs_n = 1;
    // R11/R12: early cs_n rise with CRC on, then off
    for (int k = 0; k < 2; k++) begin
      clean(); crc_check_en = (k == 0);
      @(negedge clk) cs_n = 0;
      @(negedge clk) cmd_valid = 1;
      @(negedge clk) cmd_valid = 0;
      chk(data_oe, 1, "R11 driving");
      cs_n = 1; #1;
      chk(data_oe, 0, "R11 release");
      @(negedge clk);
      chk(rsp_valid, 0, "R12 dropped");
      chk(crc_rsp_err, (k == 0), "R12 crc flag");
      @(negedge clk) chk(crc_rsp_err, (k == 0), "R12 crc hold");
      cs_n = 0;
      @(negedge clk) chk(crc_rsp_err, 0, "R12 crc clear");
      cs_n = 1;
      @(negedge clk);
    end
    // random
    for (int i = 0; i < 400; i++) begin
      int unsigned pg;
      clean();
      opcode_ok = ($urandom % 10) != 0;
      cycle_ok = ($urandom % 10) != 0;
      crc_check_en = $urandom % 2; crc_ok = ($urandom % 5) != 0;
      channel = $urandom % 4;
      pg = $urandom % 3;
      is_put = (pg == 1); is_get = (pg == 2);
      chan_free = ($urandom % 4) != 0; chan_avail = ($urandom % 4) != 0;
      rd_req = $urandom % 2;
      max_payload = LW'(64 << ($urandom % 3)); max_rd_size = LW'(64 << ($urandom % 4));
      pay_len = LW'($urandom % 300); rd_size = LW'($urandom % 600);
      addr = ($urandom % 2) ? ($urandom % 32'h200) : $urandom;
      max_vw_count = VW'($urandom % 64); vw_count = VW'($urandom % 70);
      is_io_short = $urandom % 2; io_short_only = $urandom % 2;
      run_cmd("R9 random");
    end
    finish_up();
  end
endmodule